// File: doc/BRIEF.md
# Field-Assembled Microprogram Next-Address Generator

This block produces the next control-store address for a horizontally microprogrammed engine in which no microinstruction follows its predecessor by increment. Every cycle the 12-bit address register is rebuilt from pieces: bits of its own current value, four fields of the executing microinstruction (`fa`, `fb`, `fc`, `fd`), the upper nibble of the ALU right-operand register, and up to two condition bits chosen from a vector of machine tests. Bit 0 is the rightmost address bit and bit 11 the leftmost.

Three assembly formats exist. When `fb` holds 15 the block takes a dispatch jump: the leading bits come from `fd` and `fa`, and the operand nibble picks one of sixteen address pairs. Otherwise `fd` decides. Codes 0, 1 and 3 stay inside the current 64-word block and pick a 4-word group there. Code 2 moves to another 64-word block in the same 1K region and keeps the word's group position. When `fd` is odd in a non-dispatch cycle, `fb` does not take part in addressing. Instead, `fd` and `fb` decode one of eight control strobes for that cycle.

Top module: `useq_next_addr`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `addr_q` to 0 and takes priority over `adv_en`.
- R2: With `rst` low and `adv_en` low, `addr_q` keeps its value at the edge. With `adv_en` high, it loads the assembled address.
- R3: Dispatch format (`fb` = 15): next[11:10] = `fd`, next[9:6] = `fa`, next[5] = 0, next[4:1] = `q_reg[7:4]`.
- R4: Local format with `fd` = 0 and `fb` ≠ 15: next[11:6] = current[11:6], next[5:2] = `fa`, next[1] = the test chosen by `fb`.
- R5: Local format with `fd` = 1 or 3 and `fb` ≠ 15: next[11:6] = current[11:6], next[5:2] = `fa`, next[1] = 0.
- R6: Region format with `fd` = 2 and `fb` ≠ 15: next[11:10] = current[11:10], next[9:6] = `fa`, next[5:2] = current[5:2], next[1] = the test chosen by `fb`.
- R7: In every format, next[0] is the test chosen by `fc`. A test code c gives 0 for c = 0, 1 for c = 1, `cond[c-2]` for c from 2 to 14, and 0 for c = 15.
- R8: `ctl_line` is combinational. When `fb` ≠ 15 and `fd` is 1 or 3, exactly bit {`fd[1]`, `fb[1:0]`} is high. In every other case it is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Load the assembled address this cycle |
| fa | input | 4 | Microinstruction field: block or group selector |
| fb | input | 4 | Microinstruction field: bit-1 test code, or 15 for dispatch |
| fc | input | 4 | Microinstruction field: bit-0 test code |
| fd | input | 2 | Microinstruction field: assembly format / region bits |
| q_reg | input | 8 | ALU right-operand register; its upper nibble is used |
| cond | input | TEST_W (13) | Machine test conditions, `cond[i]` selected by code i+2 |
| addr_q | output | 12 | Current control-store address |
| ctl_line | output | 8 | One-hot control strobe for odd-`fd` local cycles |

## Verification
Two functions meet in one cycle when `fd` is 1 or 3 and `fb` is not 15. The address loads with bit 1 forced low, and `fb` also selects a strobe on `ctl_line`. The bench sweeps every combination of the four fields with changing operand and condition values. It compares both the strobe, before the edge, and the loaded address, after it, against a model of the format rules, so a leak of `fb` into bit 1 or a wrong strobe index is caught in those same cycles. Reset arriving together with `adv_en`, and hold cycles with live field values, are judged in the same way.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int ADDR_W  = 12;
    localparam int FLD_W   = 4;
    localparam int FMT_W   = 2;
    localparam int CTL_N   = 8;
    localparam logic [FLD_W-1:0] DISPATCH_CODE = 4'd15;

    typedef enum logic [1:0] {
        FMT_DISPATCH,
        FMT_LOCAL,
        FMT_REGION
    } asm_fmt_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } seq_state_t;
endpackage

// File: rtl/useq_test_sel.sv
module useq_test_sel #(
    parameter int TEST_W = 13
) (
    input  logic [3:0]        code,
    input  logic [TEST_W-1:0] cond,
    output logic              bit_o
);
    always_comb begin
        bit_o = 1'b0;
        if (code == 4'd1) begin
            bit_o = 1'b1;
        end
        for (int i = 0; i < TEST_W; i++) begin
            if (int'(code) == i + 2) begin
                bit_o = cond[i];
            end
        end
    end
endmodule

// File: rtl/useq_ctl_dec.sv
module useq_ctl_dec
    import useq_pkg::*;
(
    input  asm_fmt_e          fmt,
    input  logic [FMT_W-1:0]  fd,
    input  logic [FLD_W-1:0]  fb,
    output logic [CTL_N-1:0]  ctl
);
    localparam int IDX_W = $clog2(CTL_N);

    logic             active;
    logic [IDX_W-1:0] idx;

    assign active = (fmt == FMT_LOCAL) && fd[0];
    assign idx    = {fd[1], fb[1:0]};

    for (genvar g = 0; g < CTL_N; g++) begin : g_line
        assign ctl[g] = active && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/useq_splice.sv
module useq_splice
    import useq_pkg::*;
(
    input  logic [ADDR_W-1:0] cur,
    input  logic [FLD_W-1:0]  fa,
    input  logic [FLD_W-1:0]  fb,
    input  logic [FMT_W-1:0]  fd,
    input  logic [3:0]        q_hi,
    input  logic              tb_bit,
    input  logic              tc_bit,
    output asm_fmt_e          fmt,
    output logic [ADDR_W-1:0] nxt
);
    always_comb begin
        if (fb == DISPATCH_CODE) begin
            fmt = FMT_DISPATCH;
        end else if (fd == 2'd2) begin
            fmt = FMT_REGION;
        end else begin
            fmt = FMT_LOCAL;
        end
    end

    always_comb begin
        nxt    = cur;
        nxt[0] = tc_bit;
        unique case (fmt)
            FMT_DISPATCH: begin
                nxt[11:10] = fd;
                nxt[9:6]   = fa;
                nxt[5]     = 1'b0;
                nxt[4:1]   = q_hi;
            end
            FMT_REGION: begin
                nxt[9:6] = fa;
                nxt[1]   = tb_bit;
            end
            default: begin
                nxt[5:2] = fa;
                nxt[1]   = (fd == 2'd0) ? tb_bit : 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
    import useq_pkg::*;
#(
    parameter int TEST_W = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                adv_en,
    input  logic [FLD_W-1:0]    fa,
    input  logic [FLD_W-1:0]    fb,
    input  logic [FLD_W-1:0]    fc,
    input  logic [FMT_W-1:0]    fd,
    input  logic [7:0]          q_reg,
    input  logic [TEST_W-1:0]   cond,
    output logic [ADDR_W-1:0]   addr_q,
    output logic [CTL_N-1:0]    ctl_line
);
    seq_state_t        st_d, st_q;
    asm_fmt_e          fmt;
    logic              tb_bit, tc_bit;
    logic [ADDR_W-1:0] nxt;

    useq_test_sel #(.TEST_W(TEST_W)) u_tsel_b (
        .code (fb),
        .cond (cond),
        .bit_o(tb_bit)
    );

    useq_test_sel #(.TEST_W(TEST_W)) u_tsel_c (
        .code (fc),
        .cond (cond),
        .bit_o(tc_bit)
    );

    useq_splice u_splice (
        .cur   (st_q.addr),
        .fa    (fa),
        .fb    (fb),
        .fd    (fd),
        .q_hi  (q_reg[7:4]),
        .tb_bit(tb_bit),
        .tc_bit(tc_bit),
        .fmt   (fmt),
        .nxt   (nxt)
    );

    useq_ctl_dec u_ctl (
        .fmt(fmt),
        .fd (fd),
        .fb (fb),
        .ctl(ctl_line)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.addr = '0;
        end else if (adv_en) begin
            st_d.addr = nxt;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign addr_q = st_q.addr;
endmodule

// File: rtl/useq_next_addr_chk.sv
module useq_next_addr_chk (
    input logic        clk,
    input logic        rst,
    input logic        adv_en,
    input logic [3:0]  fa,
    input logic [3:0]  fb,
    input logic [1:0]  fd,
    input logic [7:0]  q_reg,
    input logic [11:0] addr_q,
    input logic [7:0]  ctl_line
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> addr_q == 12'd0);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv_en |=> $stable(addr_q));

    // R3
    dispatch_fmt_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_en && fb == 4'd15) |=>
        (addr_q[11:10] == $past(fd) && addr_q[9:6] == $past(fa) &&
         addr_q[5] == 1'b0 && addr_q[4:1] == $past(q_reg[7:4])));

    // R4
    local_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_en && fb != 4'd15 && fd != 2'd2) |=>
        (addr_q[11:6] == $past(addr_q[11:6]) && addr_q[5:2] == $past(fa)));

    // R5
    local_bit1_low_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_en && fb != 4'd15 && fd[0]) |=> addr_q[1] == 1'b0);

    // R6
    region_fmt_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_en && fb != 4'd15 && fd == 2'd2) |=>
        (addr_q[11:10] == $past(addr_q[11:10]) && addr_q[5:2] == $past(addr_q[5:2]) &&
         addr_q[9:6] == $past(fa)));

    // R8
    ctl_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctl_line));

    // R8
    ctl_active_chk: assert property (@(posedge clk) disable iff (rst)
        ((ctl_line != 8'd0) == (fb != 4'd15 && fd[0])));
endmodule

bind useq_next_addr useq_next_addr_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .adv_en  (adv_en),
    .fa      (fa),
    .fb      (fb),
    .fd      (fd),
    .q_reg   (q_reg),
    .addr_q  (addr_q),
    .ctl_line(ctl_line)
);

// File: tb/tb_useq_next_addr.sv
`timescale 1ns/1ps
module tb_useq_next_addr;
    localparam int TW = 13;

    logic          clk = 1'b0;
    logic          rst;
    logic          adv_en;
    logic [3:0]    fa, fb, fc;
    logic [1:0]    fd;
    logic [7:0]    q_reg;
    logic [TW-1:0] cond;
    logic [11:0]   addr_q;
    logic [7:0]    ctl_line;

    int checks = 0;
    int errors = 0;
    logic [31:0] rng = 32'h1234_5678;
    logic [11:0] model = 12'd0;

    always #10 clk = ~clk;

    useq_next_addr #(.TEST_W(TW)) dut (
        .clk(clk), .rst(rst), .adv_en(adv_en),
        .fa(fa), .fb(fb), .fc(fc), .fd(fd),
        .q_reg(q_reg), .cond(cond),
        .addr_q(addr_q), .ctl_line(ctl_line)
    );

    function automatic logic tsel(input logic [3:0] c, input logic [TW-1:0] v);
        if (c == 4'd0) return 1'b0;
        if (c == 4'd1) return 1'b1;
        if (c == 4'd15) return 1'b0;
        return v[c - 4'd2];
    endfunction

    function automatic logic [11:0] assemble(input logic [11:0] cur);
        logic [11:0] n;
        if (fb == 4'd15)
            n = {fd, fa, 1'b0, q_reg[7:4], 1'b0};
        else if (fd == 2'd2)
            n = {cur[11:10], fa, cur[5:2], tsel(fb, cond), 1'b0};
        else
            n = {cur[11:6], fa, (fd == 2'd0) ? tsel(fb, cond) : 1'b0, 1'b0};
        n[0] = tsel(fc, cond);
        return n;
    endfunction

    task automatic check12(input string tag, input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic scramble();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        q_reg = rng[7:0];
        cond  = rng[20:8];
    endtask

    // Drive at a negedge, check strobe, then check address after the next edge.
    task automatic step(input string fmt_tag);
        logic [11:0] exp;
        logic [7:0]  exp_ctl;
        #1;
        exp_ctl = (fb != 4'd15 && fd[0]) ? (8'd1 << {fd[1], fb[1:0]}) : 8'd0;
        check12("R8", {4'd0, ctl_line}, {4'd0, exp_ctl});
        exp = adv_en ? assemble(model) : model;
        @(posedge clk);
        @(negedge clk);
        check12(fmt_tag, {addr_q[11:1], 1'b0}, {exp[11:1], 1'b0});
        check12("R7", {11'd0, addr_q[0]}, {11'd0, exp[0]});
        model = exp;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; adv_en = 1'b1;
        fa = 4'd5; fb = 4'd15; fc = 4'd1; fd = 2'd3; q_reg = 8'hff; cond = '1;
        @(negedge clk); @(negedge clk);
        check12("R1", addr_q, 12'd0);
        rst = 1'b0;
        model = 12'd0;

        // Exhaustive field sweep with changing data
        for (int d = 0; d < 4; d++) begin
            for (int b = 0; b < 16; b++) begin
                for (int c = 0; c < 16; c++) begin
                    for (int a = 0; a < 16; a++) begin
                        fa = 4'(a); fb = 4'(b); fc = 4'(c); fd = 2'(d);
                        scramble();
                        adv_en = 1'b1;
                        if (b == 15) step("R3");
                        else if (d == 0) step("R4");
                        else if (d == 2) step("R6");
                        else step("R5");
                    end
                end
            end
        end

        // Hold with live inputs
        for (int k = 0; k < 40; k++) begin
            scramble();
            fa = rng[3:0]; fb = rng[7:4]; fc = rng[11:8]; fd = rng[13:12];
            adv_en = 1'b0;
            step("R2");
        end

        // Reset wins over advance, mid-run
        fa = 4'd9; fb = 4'd15; fd = 2'd1; fc = 4'd1; adv_en = 1'b1; rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check12("R1", addr_q, 12'd0);
        rst = 1'b0; model = 12'd0;
        step("R3");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule